// File: doc/BRIEF.md
# Clock Generator Configuration Register File

This block holds the programming state of a root clock generator: a source select, a fractional half-step pre-divider, a counter mode and three M/N/D counter values. Software reaches five 32-bit words through a small memory-mapped bus. Every write carries a per-bit mask, so one field can be changed without a read-modify-write.

New settings first land in shadow copies and do not reach the clock datapath yet. Software then raises the update request bit in the command word. The block spends a fixed number of cycles committing the shadows into the active registers that drive the multiplexer and dividers. It swaps all fields on a single edge and drops the request bit on that same edge. Software polls the bit until it reads 0.

The command word also carries a root enable control, per-register dirty flags that show which shadows changed since the last commit, and a read-only root-off status flag.

Top module: `clkgen_cfg_regs`

## Requirements
- R1: After reset the command word (byte offset 0x0) reads 0x8000_0000. The configuration (0x4), M (0x8), N (0xC) and D (0x10) words read 0. All active outputs and `root_en` are 0.
- R2: A write changes only the bits whose `bus_wmask` bit is 1. The configuration word keeps the pre-divider in bits [HID_W-1:0], the source select in bits [10:8] and the mode in bits [13:12]; all of its other bits read 0. M, N and D keep bits [MND_W-1:0], and their upper bits read 0.
- R3: An accepted write to configuration, N, M or D sets command bit 4, 5, 6 or 7 respectively.
- R4: Shadow writes leave the active outputs unchanged until an update commits.
- R5: Writing 1 to command bit 0, with mask bit 0 set, starts an update. Bit 0 then reads 1 for exactly COMMIT_CYCLES cycles. On the edge where it clears, the active outputs take the shadow values and all dirty flags clear.
- R6: While an update is pending, writes to configuration, M, N and D are dropped. The shadows keep their values and no dirty flag is set.
- R7: Command bit 1 is a read/write root enable that drives `root_en`. Bit 31 reads 1 exactly when root enable is 0. Writes to bits 31 and 7:4 have no effect.
- R8: Any offset other than the five word offsets reads 0, and a write to it changes no register.
- R9: A command write that has bit 0 at 0 in either its data or its mask does not start an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the register file and the commit logic |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | AW | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_wmask | input | 32 | Per-bit write enable |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| root_en | output | 1 | Root enable control |
| act_div | output | HID_W | Active half-step pre-divider |
| act_src | output | 3 | Active source select |
| act_mode | output | 2 | Active counter mode (2 = dual edge) |
| act_m | output | MND_W | Active M value |
| act_n | output | MND_W | Active N value |
| act_d | output | MND_W | Active D value |

## Verification
The update handshake is tried with four command write patterns: data and mask both set, data clear, mask clear, and a start followed at once by a configuration write. Together they separate a true start from a rejected one and show that the lock drops late writes. Masked writes use all-ones data under narrow masks, which exposes any bit that leaks outside its mask or outside a field. Sampling the active outputs on every pending cycle and then right after the clear shows whether the swap happens early, late or field by field.

// File: rtl/clkgen_regs_pkg.sv
package clkgen_regs_pkg;

    localparam int NREG     = 5;
    localparam int IDX_CMD  = 0;
    localparam int IDX_CFG  = 1;
    localparam int IDX_M    = 2;
    localparam int IDX_N    = 3;
    localparam int IDX_D    = 4;

    localparam int BIT_UPD      = 0;
    localparam int BIT_ROOT_EN  = 1;
    localparam int DIRTY_LSB    = 4;
    localparam int BIT_ROOT_OFF = 31;

    localparam int SRC_LSB  = 8;
    localparam int SRC_W    = 3;
    localparam int MODE_LSB = 12;
    localparam int MODE_W   = 2;
    localparam int DIV_MAXW = 8;

    typedef struct packed {
        logic [MODE_W-1:0]   mode;
        logic [SRC_W-1:0]    src;
        logic [DIV_MAXW-1:0] div;
    } cfg_fields_t;

    function automatic logic [31:0] masked_merge(input logic [31:0] old_v,
                                                 input logic [31:0] new_v,
                                                 input logic [31:0] mask);
        return (old_v & ~mask) | (new_v & mask);
    endfunction

    function automatic logic [31:0] cfg_rw_mask(input int hid_w);
        logic [31:0] m;
        m = (32'd1 << hid_w) - 32'd1;
        m |= ((32'd1 << SRC_W) - 32'd1) << SRC_LSB;
        m |= ((32'd1 << MODE_W) - 32'd1) << MODE_LSB;
        return m;
    endfunction

    function automatic logic [31:0] reg_offset(input int idx);
        return 32'(idx * 4);
    endfunction

    // dirty slot: 0 = configuration, 1 = N, 2 = M, 3 = D
    function automatic int dirty_slot(input int idx);
        case (idx)
            IDX_CFG: return 0;
            IDX_N:   return 1;
            IDX_M:   return 2;
            default: return 3;
        endcase
    endfunction

    function automatic cfg_fields_t unpack_cfg(input logic [31:0] w);
        cfg_fields_t f;
        f.mode = w[MODE_LSB +: MODE_W];
        f.src  = w[SRC_LSB +: SRC_W];
        f.div  = w[DIV_MAXW-1:0];
        return f;
    endfunction

endpackage

// File: rtl/clkgen_addr_decode.sv
module clkgen_addr_decode
    import clkgen_regs_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0]   addr,
    output logic [NREG-1:0] sel
);
    for (genvar g = 0; g < NREG; g++) begin : g_sel
        assign sel[g] = (addr == AW'(reg_offset(g)));
    end
endmodule

// File: rtl/clkgen_commit_ctrl.sv
module clkgen_commit_ctrl #(
    parameter int COMMIT_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic pend,
    output logic commit
);
    localparam int CW = $clog2(COMMIT_CYCLES + 1);

    logic [CW-1:0] cnt;

    assign commit = pend && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            pend <= 1'b1;
            cnt  <= CW'(COMMIT_CYCLES - 1);
        end else if (commit) begin
            pend <= 1'b0;
        end else if (pend) begin
            cnt  <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/clkgen_active_bank.sv
module clkgen_active_bank
    import clkgen_regs_pkg::*;
#(
    parameter int HID_W = 5,
    parameter int MND_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  cfg_fields_t       sh_cfg,
    input  logic [MND_W-1:0]  sh_m,
    input  logic [MND_W-1:0]  sh_n,
    input  logic [MND_W-1:0]  sh_d,
    output logic [HID_W-1:0]  act_div,
    output logic [SRC_W-1:0]  act_src,
    output logic [MODE_W-1:0] act_mode,
    output logic [MND_W-1:0]  act_m,
    output logic [MND_W-1:0]  act_n,
    output logic [MND_W-1:0]  act_d
);
    always_ff @(posedge clk) begin
        if (rst) begin
            act_div  <= '0;
            act_src  <= '0;
            act_mode <= '0;
            act_m    <= '0;
            act_n    <= '0;
            act_d    <= '0;
        end else if (commit) begin
            act_div  <= sh_cfg.div[HID_W-1:0];
            act_src  <= sh_cfg.src;
            act_mode <= sh_cfg.mode;
            act_m    <= sh_m;
            act_n    <= sh_n;
            act_d    <= sh_d;
        end
    end
endmodule

// File: rtl/clkgen_cfg_regs.sv
module clkgen_cfg_regs
    import clkgen_regs_pkg::*;
#(
    parameter int AW            = 5,
    parameter int HID_W         = 5,
    parameter int MND_W         = 8,
    parameter int COMMIT_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_wmask,
    output logic [31:0]       bus_rdata,
    output logic              root_en,
    output logic [HID_W-1:0]  act_div,
    output logic [2:0]        act_src,
    output logic [1:0]        act_mode,
    output logic [MND_W-1:0]  act_m,
    output logic [MND_W-1:0]  act_n,
    output logic [MND_W-1:0]  act_d
);
    localparam logic [31:0] CFG_MASK = cfg_rw_mask(HID_W);
    localparam int          NMND     = 3;

    logic [NREG-1:0]  sel;
    logic [NREG-1:0]  wr_hit;
    logic             upd_pend;
    logic             commit;
    logic             start;
    logic [31:0]      cfg_sh;
    logic [MND_W-1:0] mnd_sh [NMND];
    logic [3:0]       dirty;
    logic [3:0]       dirty_nx;
    logic             root_en_q;

    clkgen_addr_decode #(.AW(AW)) i_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    // shadow writes are locked while an update is pending
    assign wr_hit = (bus_wr && !upd_pend) ? sel : '0;
    assign start  = bus_wr && sel[IDX_CMD] && bus_wmask[BIT_UPD]
                    && bus_wdata[BIT_UPD] && !upd_pend;

    clkgen_commit_ctrl #(.COMMIT_CYCLES(COMMIT_CYCLES)) i_commit (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .pend   (upd_pend),
        .commit (commit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_sh <= '0;
        end else if (wr_hit[IDX_CFG]) begin
            cfg_sh <= masked_merge(cfg_sh, bus_wdata, bus_wmask) & CFG_MASK;
        end
    end

    for (genvar g = 0; g < NMND; g++) begin : g_mnd
        localparam int RI = IDX_M + g;
        always_ff @(posedge clk) begin
            if (rst) begin
                mnd_sh[g] <= '0;
            end else if (wr_hit[RI]) begin
                mnd_sh[g] <= MND_W'(masked_merge(32'(mnd_sh[g]), bus_wdata, bus_wmask));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            root_en_q <= 1'b0;
        end else if (bus_wr && sel[IDX_CMD] && bus_wmask[BIT_ROOT_EN]) begin
            root_en_q <= bus_wdata[BIT_ROOT_EN];
        end
    end

    always_comb begin
        dirty_nx = dirty;
        if (commit) begin
            dirty_nx = '0;
        end
        for (int i = IDX_CFG; i < NREG; i++) begin
            if (wr_hit[i]) begin
                dirty_nx[dirty_slot(i)] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dirty <= '0;
        end else begin
            dirty <= dirty_nx;
        end
    end

    clkgen_active_bank #(.HID_W(HID_W), .MND_W(MND_W)) i_bank (
        .clk      (clk),
        .rst      (rst),
        .commit   (commit),
        .sh_cfg   (unpack_cfg(cfg_sh)),
        .sh_m     (mnd_sh[0]),
        .sh_n     (mnd_sh[1]),
        .sh_d     (mnd_sh[2]),
        .act_div  (act_div),
        .act_src  (act_src),
        .act_mode (act_mode),
        .act_m    (act_m),
        .act_n    (act_n),
        .act_d    (act_d)
    );

    assign root_en = root_en_q;

    always_comb begin
        bus_rdata = '0;
        if (sel[IDX_CMD]) begin
            bus_rdata[BIT_UPD]                = upd_pend;
            bus_rdata[BIT_ROOT_EN]            = root_en_q;
            bus_rdata[DIRTY_LSB +: 4]         = dirty;
            bus_rdata[BIT_ROOT_OFF]           = !root_en_q;
        end else if (sel[IDX_CFG]) begin
            bus_rdata = cfg_sh;
        end else begin
            for (int i = 0; i < NMND; i++) begin
                if (sel[IDX_M + i]) begin
                    bus_rdata = 32'(mnd_sh[i]);
                end
            end
        end
    end
endmodule

// File: rtl/clkgen_cfg_regs_chk.sv
module clkgen_cfg_regs_chk #(
    parameter int AW    = 5,
    parameter int ACT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic [AW-1:0]    bus_addr,
    input logic [31:0]      bus_rdata,
    input logic             upd_pend,
    input logic [3:0]       dirty,
    input logic [31:0]      cfg_sh,
    input logic [ACT_W-1:0] act_all
);
    logic mapped;
    assign mapped = (bus_addr[1:0] == 2'b00) && (32'(bus_addr) < 32'd20);

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !upd_pend |=> $stable(act_all)); // R4

    AST_DIRTY_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(upd_pend) |-> (dirty == 4'b0000)); // R5

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && upd_pend && (32'(bus_addr) == 32'd4)) |=> $stable(cfg_sh)); // R6

    AST_NO_DIRTY_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (upd_pend && $past(upd_pend)) |-> ((dirty & ~$past(dirty)) == 4'b0000)); // R6

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        !mapped |-> (bus_rdata == 32'd0)); // R8
endmodule

bind clkgen_cfg_regs clkgen_cfg_regs_chk #(
    .AW    (AW),
    .ACT_W (HID_W + 5 + 3 * MND_W)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .upd_pend  (upd_pend),
    .dirty     (dirty),
    .cfg_sh    (cfg_sh),
    .act_all   ({act_mode, act_src, act_div, act_m, act_n, act_d})
);

// File: tb/test_clkgen_cfg_regs.sv
module test_clkgen_cfg_regs;

    localparam int AW = 5;
    localparam int HID_W = 5;
    localparam int MND_W = 8;
    localparam int COMMIT_CYCLES = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bus_wr = 1'b0;
    logic [AW-1:0]    bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_wmask = '0;
    logic [31:0]      bus_rdata;
    logic             root_en;
    logic [HID_W-1:0] act_div;
    logic [2:0]       act_src;
    logic [1:0]       act_mode;
    logic [MND_W-1:0] act_m, act_n, act_d;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #4 clk = ~clk;

    clkgen_cfg_regs #(
        .AW(AW), .HID_W(HID_W), .MND_W(MND_W), .COMMIT_CYCLES(COMMIT_CYCLES)
    ) i_clkgen_cfg_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wmask(bus_wmask), .bus_rdata(bus_rdata),
        .root_en(root_en), .act_div(act_div), .act_src(act_src),
        .act_mode(act_mode), .act_m(act_m), .act_n(act_n), .act_d(act_d)
    );

    // kind 0 = read data, 1 = active config in register layout, 2/3/4 = active M/N/D, 5 = root_en
    function automatic logic [31:0] observe(input int kind);
        case (kind)
            0: return bus_rdata;
            1: return (32'(act_mode) << 12) | (32'(act_src) << 8) | 32'(act_div);
            2: return 32'(act_m);
            3: return 32'(act_n);
            4: return 32'(act_d);
            default: return 32'(root_en);
        endcase
    endfunction

    task automatic check32(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check32(observe(it.kind), it.exp, it.tag);
        end
    end

    task automatic expect_obs(input int kind, input logic [31:0] addr,
                              input logic [31:0] exp, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        if (kind == 0) bus_addr = AW'(addr);
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        sb_q.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic bus_write(input logic [31:0] addr, input logic [31:0] data,
                             input logic [31:0] mask);
        @(posedge clk);
        #1;
        bus_wr    = 1'b1;
        bus_addr  = AW'(addr);
        bus_wdata = data;
        bus_wmask = mask;
        @(posedge clk);
        #1;
        bus_wr    = 1'b0;
        bus_wmask = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int pend_cnt;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        expect_obs(0, 32'h0,  32'h8000_0000, "R1 cmd after reset");
        expect_obs(0, 32'h4,  32'h0, "R1 cfg after reset");
        expect_obs(0, 32'h8,  32'h0, "R1 M after reset");
        expect_obs(0, 32'hC,  32'h0, "R1 N after reset");
        expect_obs(0, 32'h10, 32'h0, "R1 D after reset");
        expect_obs(1, 32'h0,  32'h0, "R1 active cfg after reset");
        expect_obs(5, 32'h0,  32'h0, "R1 root_en after reset");

        // R2 masked writes and field layout
        bus_write(32'h4, 32'h0000_2305, 32'hFFFF_FFFF);
        expect_obs(0, 32'h4, 32'h0000_2305, "R2 cfg full write");
        bus_write(32'h4, 32'hFFFF_FFFF, 32'h0000_0700);
        expect_obs(0, 32'h4, 32'h0000_2705, "R2 cfg src-only mask");
        bus_write(32'h4, 32'hFFFF_FFFF, 32'hFFFF_0000);
        expect_obs(0, 32'h4, 32'h0000_2705, "R2 cfg bits outside fields");
        expect_obs(0, 32'h0, 32'h8000_0010, "R3 cfg dirty flag");
        expect_obs(1, 32'h0, 32'h0, "R4 active cfg held");

        bus_write(32'h8,  32'h0000_0011, 32'hFFFF_FFFF);
        bus_write(32'hC,  32'hFFFF_FFEE, 32'hFFFF_FFFF);
        bus_write(32'h10, 32'h0000_005A, 32'h0000_00FF);
        expect_obs(0, 32'h8, 32'h11, "R2 M value");
        expect_obs(0, 32'hC, 32'hEE, "R2 N upper bits read zero");
        expect_obs(0, 32'h0, 32'h8000_00F0, "R3 all dirty flags");
        expect_obs(2, 32'h0, 32'h0, "R4 active M held");

        // R9 rejected update starts
        bus_write(32'h0, 32'h0, 32'h1);
        expect_obs(0, 32'h0, 32'h8000_00F0, "R9 data bit clear");
        bus_write(32'h0, 32'h1, 32'h0);
        expect_obs(0, 32'h0, 32'h8000_00F0, "R9 mask bit clear");

        // R5 update handshake timing
        bus_write(32'h0, 32'h1, 32'h1);
        bus_addr = '0;
        pend_cnt = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (bus_rdata[0] !== 1'b1) break;
            pend_cnt++;
            check32(observe(1), 32'h0, "R5 active cfg old while pending");
        end
        check32(32'(pend_cnt), 32'(COMMIT_CYCLES), "R5 pending cycle count");
        check32(observe(1), 32'h0000_2705, "R5 active cfg after commit");
        check32(observe(2), 32'h11, "R5 active M after commit");
        check32(observe(3), 32'hEE, "R5 active N after commit");
        check32(observe(4), 32'h5A, "R5 active D after commit");
        check32(bus_rdata, 32'h8000_0000, "R5 dirty cleared by commit");

        // R6 lock during pending update
        bus_write(32'h0, 32'h1, 32'h1);
        bus_write(32'h4, 32'h0, 32'hFFFF_FFFF);
        repeat (6) @(posedge clk);
        expect_obs(0, 32'h4, 32'h0000_2705, "R6 cfg write dropped");
        expect_obs(0, 32'h0, 32'h8000_0000, "R6 no dirty from dropped write");

        // R7 root enable and read-only bits
        bus_write(32'h0, 32'hFFFF_FFFE, 32'hFFFF_FFFE);
        expect_obs(0, 32'h0, 32'h0000_0002, "R7 root enabled, RO bits kept");
        expect_obs(5, 32'h0, 32'h1, "R7 root_en port high");
        bus_write(32'h0, 32'h0, 32'h2);
        expect_obs(0, 32'h0, 32'h8000_0000, "R7 root disabled");
        expect_obs(5, 32'h0, 32'h0, "R7 root_en port low");

        // R8 unmapped offsets
        bus_write(32'h14, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        bus_write(32'h2,  32'hFFFF_FFFF, 32'hFFFF_FFFF);
        expect_obs(0, 32'h14, 32'h0, "R8 unmapped read 0x14");
        expect_obs(0, 32'h2,  32'h0, "R8 unmapped read 0x2");
        expect_obs(0, 32'h4,  32'h0000_2705, "R8 cfg untouched");
        expect_obs(0, 32'h8,  32'h11, "R8 M untouched");
        expect_obs(0, 32'h0,  32'h8000_0000, "R8 cmd untouched");

        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule